// File: doc/BRIEF.md
# Bus Clock Source Switchover Sequencer

This block manages which clock drives the ATA bus of a two-channel disk controller. Two sources are available: a PLL output and the host bus clock. Whenever a command is issued, the block works out which source that command needs. It then checks whether the source may be changed at this moment. When both answers call for a change, it takes the bus through a fixed, guarded sequence before the command is allowed to go ahead.

The sequence has six steps:

1. Electrically isolate both channels from the cable.
2. Drive the new source-select code.
3. Hold the channels in reset.
4. Reset both channel state machines.
5. Release the reset.
6. Reconnect the channels.

Each step holds its outputs for a programmable number of cycles. The issue-grant pulse comes one cycle after the last step. When no change is needed, or when the change is not allowed, the grant comes in the same cycle as the request.

A request is a single-cycle pulse that carries a write flag. A static flag reports whether the host bus runs at 66 MHz. Another input reports whether the partner channel is idle. The block records its current source, and that record changes only when a sequence completes.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset the block has all of the following: tristate outputs 2'b00, source code 8'h23 (host bus clock), channel-reset code 8'h00, state-machine-reset code 8'h00, grant low and busy low.
- R2: A request needs the PLL source when its write flag is set or when the 66 MHz flag is set. Otherwise it needs the host bus clock.
- R3: While the partner channel is not idle, a request never starts a sequence. It is granted in the same cycle and busy stays low.
- R4: A request whose needed source equals the recorded source is granted in the same cycle, and no output other than the grant changes.
- R5: A sequence drives its steps in this order: tristate 2'b11 with the old code; the new code; channel-reset code 8'hC0; 8'hC0 together with state-machine-reset code 8'h37 on both channels; both reset codes 8'h00; tristate 2'b00.
- R6: Each of the six steps lasts exactly STEP_CYCLES clock cycles.
- R7: After the reconnect step the grant is high for exactly one cycle. The block is then idle again.
- R8: The source code is 8'h21 for the PLL and 8'h23 for the host bus clock. It changes only while both channels are tristated. The recorded source takes the new value only when a sequence completes.
- R9: A request that arrives while the block is busy is ignored: it produces no grant and does not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_req | input | 1 | Single-cycle command issue request |
| issue_write | input | 1 | Request is a write |
| host_fast | input | 1 | Host bus runs at 66 MHz |
| partner_idle | input | 1 | Partner channel is idle |
| chan_tristate | output | 2 | Per-channel bus isolation |
| src_sel_code | output | 8 | Clock source select code |
| chan_rst_code | output | 8 | Channel reset control code |
| sm_rst_code | output | 8 | Channel state-machine reset code |
| busy | output | 1 | Switch sequence in progress |
| issue_grant | output | 1 | Command may issue now |

## Verification
The bench issues the following request patterns, each chosen to separate one part of the decision:

- Reads on a slow host bus, which need no switch.
- Writes while the partner channel is busy, which separate the partner gate from the source comparison.
- Writes and fast-bus reads with the partner idle, which separate the two causes that make the PLL necessary.
- A slow read after a switch, which forces the return to the host clock.
- Requests fired in the middle of a sequence, which show that busy requests are ignored.

A behavioural model predicts every output on every clock. A wrong step order, a wrong step length, a wrong code or an early source update therefore shows up in the first cycle where it differs.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISOLATE,
    ST_SELECT,
    ST_HOLD,
    ST_SMRST,
    ST_RELEASE,
    ST_RECONNECT,
    ST_GRANT
  } sw_state_t;

  localparam logic [7:0] CODE_SRC_PLL  = 8'h21;
  localparam logic [7:0] CODE_SRC_HOST = 8'h23;
  localparam logic [7:0] CODE_CHAN_RST = 8'hC0;
  localparam logic [7:0] CODE_SM_RST   = 8'h37;
  localparam logic [7:0] CODE_OFF      = 8'h00;

endpackage

// File: rtl/clksw_policy.sv
module clksw_policy (
  input  logic is_write,
  input  logic host_fast,
  input  logic partner_idle,
  input  logic cur_pll,
  output logic need_pll,
  output logic switch_ok
);

  always_comb begin
    need_pll  = is_write | host_fast;
    switch_ok = partner_idle & (need_pll != cur_pll);
  end

endmodule

// File: rtl/clksw_step_timer.sv
module clksw_step_timer #(
  parameter int unsigned STEP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_done
);

  localparam int unsigned CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    step_done = run & (cnt_q == LAST);
    cnt_en    = run | (cnt_q != '0);
    cnt_d     = (!run || step_done) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  a_r6_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
#(
  parameter bit RESET_PLL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      need_pll,
  input  logic      switch_ok,
  input  logic      step_done,
  output sw_state_t state,
  output logic      cur_pll,
  output logic      tgt_pll,
  output logic      grant
);

  sw_state_t state_d;
  logic      tgt_en, cur_en;

  always_comb begin
    state_d = state;
    tgt_en  = 1'b0;
    cur_en  = 1'b0;
    unique case (state)
      ST_IDLE: if (req && switch_ok) begin
        state_d = ST_ISOLATE;
        tgt_en  = 1'b1;
      end
      ST_ISOLATE:   if (step_done) state_d = ST_SELECT;
      ST_SELECT:    if (step_done) state_d = ST_HOLD;
      ST_HOLD:      if (step_done) state_d = ST_SMRST;
      ST_SMRST:     if (step_done) state_d = ST_RELEASE;
      ST_RELEASE:   if (step_done) state_d = ST_RECONNECT;
      ST_RECONNECT: if (step_done) begin
        state_d = ST_GRANT;
        cur_en  = 1'b1;
      end
      ST_GRANT:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
    grant = (state == ST_GRANT) || ((state == ST_IDLE) && req && !switch_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tgt_pll <= RESET_PLL;
      cur_pll <= RESET_PLL;
    end else begin
      state <= state_d;
      if (tgt_en) tgt_pll <= need_pll;
      if (cur_en) cur_pll <= tgt_pll;
    end
  end

  a_r3_partner_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !switch_ok) |=> (state == ST_IDLE));

  a_r8_source_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pll != $past(cur_pll)) |-> (state == ST_GRANT));

  a_r9_busy_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(tgt_pll));

endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
  import clksw_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 3,
  parameter bit          RESET_PLL   = 1'b0,
  parameter int unsigned NUM_CHAN    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_req,
  input  logic                issue_write,
  input  logic                host_fast,
  input  logic                partner_idle,
  output logic [NUM_CHAN-1:0] chan_tristate,
  output logic [7:0]          src_sel_code,
  output logic [7:0]          chan_rst_code,
  output logic [7:0]          sm_rst_code,
  output logic                busy,
  output logic                issue_grant
);

  sw_state_t state;
  logic need_pll, switch_ok, step_done, cur_pll, tgt_pll, run;

  clksw_policy u_policy (
    .is_write    (issue_write),
    .host_fast   (host_fast),
    .partner_idle(partner_idle),
    .cur_pll     (cur_pll),
    .need_pll    (need_pll),
    .switch_ok   (switch_ok)
  );

  clksw_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .step_done(step_done)
  );

  clksw_fsm #(.RESET_PLL(RESET_PLL)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (issue_req),
    .need_pll (need_pll),
    .switch_ok(switch_ok),
    .step_done(step_done),
    .state    (state),
    .cur_pll  (cur_pll),
    .tgt_pll  (tgt_pll),
    .grant    (issue_grant)
  );

  logic isolate, new_sel;

  always_comb begin
    run     = (state != ST_IDLE) && (state != ST_GRANT);
    busy    = (state != ST_IDLE);
    isolate = (state == ST_ISOLATE) || (state == ST_SELECT) || (state == ST_HOLD) ||
              (state == ST_SMRST)   || (state == ST_RELEASE);
    new_sel = run && (state != ST_ISOLATE);
    src_sel_code  = (new_sel ? tgt_pll : cur_pll) ? CODE_SRC_PLL : CODE_SRC_HOST;
    chan_rst_code = ((state == ST_HOLD) || (state == ST_SMRST)) ? CODE_CHAN_RST : CODE_OFF;
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    assign chan_tristate[c] = isolate;
  end

  assign sm_rst_code = (state == ST_SMRST) ? CODE_SM_RST : CODE_OFF;

  a_r5_reset_while_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rst_code != CODE_OFF) |-> (&chan_tristate));

  a_r5_sm_reset_inside_chan_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_rst_code != CODE_OFF) |-> (chan_rst_code == CODE_CHAN_RST));

  a_r8_select_moves_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_code != $past(src_sel_code)) |-> (&chan_tristate));

  a_r7_grant_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant && busy) |=> !busy);

endmodule

// File: tb/sim_clk_switch_seq.sv
module sim_clk_switch_seq;

  localparam int STEP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_req = 1'b0, issue_write = 1'b0, host_fast = 1'b0, partner_idle = 1'b1;
  logic [1:0] chan_tristate;
  logic [7:0] src_sel_code, chan_rst_code, sm_rst_code;
  logic busy, issue_grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model: phase 0 idle, 1..6 steps, 7 grant
  int m_phase = 0;
  int m_cnt   = 0;
  bit m_cur   = 0;
  bit m_tgt   = 0;

  always #10 clk = ~clk;

  clk_switch_seq #(.STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .issue_write(issue_write),
    .host_fast(host_fast), .partner_idle(partner_idle), .chan_tristate(chan_tristate),
    .src_sel_code(src_sel_code), .chan_rst_code(chan_rst_code), .sm_rst_code(sm_rst_code),
    .busy(busy), .issue_grant(issue_grant)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit m_need();
    return issue_write | host_fast;
  endfunction

  function automatic bit m_starts();
    return (m_phase == 0) && issue_req && partner_idle && (m_need() != m_cur);
  endfunction

  task automatic compare(string tag);
    int e_tri, e_sel, e_crst, e_smr, e_grant;
    e_tri   = (m_phase >= 1 && m_phase <= 5) ? 3 : 0;
    e_sel   = (m_phase >= 2 && m_phase <= 6) ? (m_tgt ? 'h21 : 'h23) : (m_cur ? 'h21 : 'h23);
    e_crst  = (m_phase == 3 || m_phase == 4) ? 'hC0 : 0;
    e_smr   = (m_phase == 4) ? 'h37 : 0;
    e_grant = (m_phase == 7) || (m_phase == 0 && issue_req && !m_starts());
    chk(tag, "tristate", chan_tristate, e_tri);
    chk(tag, "src_sel",  src_sel_code,  e_sel);
    chk(tag, "chan_rst", chan_rst_code, e_crst);
    chk(tag, "sm_rst",   sm_rst_code,   e_smr);
    chk(tag, "grant",    issue_grant,   e_grant);
    chk(tag, "busy",     busy,          int'(m_phase != 0));
  endtask

  task automatic model_update();
    if (m_phase == 0) begin
      if (m_starts()) begin
        m_tgt = m_need(); m_phase = 1; m_cnt = 0;
      end
    end else if (m_phase == 7) begin
      m_phase = 0;
    end else if (m_cnt == STEP - 1) begin
      m_cnt = 0;
      if (m_phase == 6) m_cur = m_tgt;
      m_phase++;
    end else begin
      m_cnt++;
    end
  endtask

  // called at a negative edge: drive, compare, advance one clock
  task automatic cyc(string tag, bit req, bit wr, bit fast, bit pidle);
    issue_req = req; issue_write = wr; host_fast = fast; partner_idle = pidle;
    #2 compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_cycles(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #2 compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_cycles("R1", 2);

    // slow read, host clock already in use: immediate grant
    cyc("R4", 1, 0, 0, 1);
    idle_cycles("R4", 2);
    // write with partner busy: no switch
    cyc("R3", 1, 1, 0, 0);
    idle_cycles("R3", 2);
    // write, partner idle: switch to PLL, with stray requests mid-sequence
    cyc("R2", 1, 1, 0, 1);
    for (int i = 0; i < 6 * STEP + 1; i++)
      cyc((i % 5 == 2) ? "R9" : "R5", (i % 5 == 2), 0, 0, 1);
    idle_cycles("R7", 2);
    // fast-bus read needs PLL: already there
    cyc("R2", 1, 0, 1, 1);
    idle_cycles("R4", 1);
    // slow read: back to host clock
    cyc("R8", 1, 0, 0, 1);
    for (int i = 0; i < 6 * STEP + 1; i++) cyc("R6", 0, 0, 0, 1);
    // fast-bus read with partner idle: to PLL again, back-to-back requests
    cyc("R2", 1, 0, 1, 1);
    for (int i = 0; i < 6 * STEP + 1; i++) cyc("R6", 0, 0, 1, 1);
    cyc("R7", 1, 0, 0, 0);
    cyc("R7", 1, 1, 1, 1);
    idle_cycles("R7", 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule